// File: doc/BRIEF.md
# Scanned-Bank Seven-Segment Glyph Decoder

This block sits behind the scan sequencer of a five-bank multiplexed LED display. Each scan step, the sequencer presents the index of the bank being lit. The block picks that bank's 4-bit nibble out of the 24-bit display word and turns it into seven segment lines plus the decimal/annunciator line (h). The result is registered, so it is ready for the anode drivers one clock later.

Each bank has its own mode bit in the 8-bit configuration word. That bit chooses between hexadecimal glyphs and a group mode. The group mode is set by one of two shared bits: one covers the low three banks and the other covers the upper two. It gives either a fixed table of letters and symbols or raw pass-through of the nibble, which is used for discrete lamps and annunciators. A separate 3-bit code in the display word chooses which banks light h. This code works the same way whatever the decode mode is.

Top module: `seg_bank_decoder`

## Requirements
- R1: While rst_n is low, seg_out and h_out are 0.
- R2: The outputs are registered. Inputs sampled at one rising clock edge appear on seg_out and h_out after that edge and stay until the next edge.
- R3: bank_sel value k, for k from 0 to 4 (bank 1 to bank 5), selects nibble disp_word[4k+3:4k], with its LSB at bit 4k.
- R4: Bank k decodes in hex when cfg_word[k+1] is 0. When cfg_word[k+1] is 1, it uses the group mode. The group bit is cfg_word[6] for k = 0..2 and cfg_word[7] for k = 3..4. A group bit of 1 means the symbol table and 0 means raw pass-through.
- R5: Hex glyphs for nibbles 0..F, as seg_out in hex: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. Segment a is bit 0 and g is bit 6, active high.
- R6: Symbol-table glyphs for nibbles 0..F: 58 76 74 1E 38 54 5C 73 50 3E 1C 6E 40 48 63 00. These are c H h J L n o P r U u y, dash, equals, degree and blank.
- R7: In raw mode, seg_out[3:0] equals the nibble (a = nibble bit 0) and seg_out[6:4] are 0.
- R8: The code disp_word[22:20] controls h. Code 0 lights no bank. Codes 1..5 light bank 1..5 only (bank_sel = code-1). Code 6 lights banks 1 and 2. Code 7 lights all banks.
- R9: h_out depends only on the h code and bank_sel, and is the same in hex, symbol and raw modes.
- R10: bank_sel values 5, 6 and 7 give seg_out = 0 and h_out = 0.
- R11: disp_word[23] and cfg_word[0] have no effect on seg_out or h_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_word | input | 24 | Five bank nibbles, h code in [22:20], bit 23 unused |
| cfg_word | input | 8 | Per-bank mode bits [5:1], group bits [7:6], bit 0 unused |
| bank_sel | input | 3 | Index of the bank being scanned (0..4) |
| seg_out | output | 7 | Segments a (bit 0) to g (bit 6), active high |
| h_out | output | 1 | Decimal/annunciator anode for the scanned bank |

## Verification
The assertions assume that disp_word, cfg_word and bank_sel are stable across each rising edge. They also assume these inputs hold known values once reset is released, because every property compares the registered output with the past value of those inputs. The bench changes inputs only on falling edges and drives defined values from time zero. The random stimulus covers all eight bank_sel values, including the three out-of-range indices, and any cfg_word value, so every per-bank mode mix is reached.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
    localparam int SEG_W = 7;

    typedef enum logic [1:0] {
        MODE_HEX     = 2'd0,
        MODE_SPECIAL = 2'd1,
        MODE_RAW     = 2'd2
    } glyph_mode_e;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic             h;
    } drive_s;
endpackage

// File: rtl/segdec_bank_select.sv
module segdec_bank_select
    import segdec_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int NIB_W     = 4,
    parameter int SEL_W     = 3,
    parameter int GRP_SPLIT = 3,
    parameter int DISP_W    = 24,
    parameter int CFG_W     = 8
) (
    input  logic [DISP_W-1:0] disp,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [SEL_W-1:0]  sel,
    output logic [NIB_W-1:0]  nib,
    output glyph_mode_e       mode,
    output logic              valid
);
    localparam int GRP_LO_BIT = NUM_BANKS + 1;
    localparam int GRP_HI_BIT = NUM_BANKS + 2;

    logic [NIB_W-1:0] nib_arr  [NUM_BANKS];
    glyph_mode_e      mode_arr [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic grp_bit;
        if (g < GRP_SPLIT) begin : g_lo
            assign grp_bit = cfg[GRP_LO_BIT];
        end else begin : g_hi
            assign grp_bit = cfg[GRP_HI_BIT];
        end
        assign nib_arr[g]  = disp[g*NIB_W +: NIB_W];
        assign mode_arr[g] = !cfg[g+1] ? MODE_HEX
                           : (grp_bit ? MODE_SPECIAL : MODE_RAW);
    end

    always_comb begin
        nib   = '0;
        mode  = MODE_HEX;
        valid = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (sel == SEL_W'(i)) begin
                nib   = nib_arr[i];
                mode  = mode_arr[i];
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/segdec_glyph_rom.sv
module segdec_glyph_rom
    import segdec_pkg::*;
(
    input  logic [3:0]       nib,
    input  glyph_mode_e      mode,
    output logic [SEG_W-1:0] seg
);
    logic [SEG_W-1:0] hex_seg;
    logic [SEG_W-1:0] sym_seg;

    always_comb begin
        case (nib)
            4'h0: hex_seg = 7'h3F;
            4'h1: hex_seg = 7'h06;
            4'h2: hex_seg = 7'h5B;
            4'h3: hex_seg = 7'h4F;
            4'h4: hex_seg = 7'h66;
            4'h5: hex_seg = 7'h6D;
            4'h6: hex_seg = 7'h7D;
            4'h7: hex_seg = 7'h07;
            4'h8: hex_seg = 7'h7F;
            4'h9: hex_seg = 7'h6F;
            4'hA: hex_seg = 7'h77;
            4'hB: hex_seg = 7'h7C;
            4'hC: hex_seg = 7'h39;
            4'hD: hex_seg = 7'h5E;
            4'hE: hex_seg = 7'h79;
            default: hex_seg = 7'h71;
        endcase
    end

    always_comb begin
        case (nib)
            4'h0: sym_seg = 7'h58;  // c
            4'h1: sym_seg = 7'h76;  // H
            4'h2: sym_seg = 7'h74;  // h
            4'h3: sym_seg = 7'h1E;  // J
            4'h4: sym_seg = 7'h38;  // L
            4'h5: sym_seg = 7'h54;  // n
            4'h6: sym_seg = 7'h5C;  // o
            4'h7: sym_seg = 7'h73;  // P
            4'h8: sym_seg = 7'h50;  // r
            4'h9: sym_seg = 7'h3E;  // U
            4'hA: sym_seg = 7'h1C;  // u
            4'hB: sym_seg = 7'h6E;  // y
            4'hC: sym_seg = 7'h40;  // dash
            4'hD: sym_seg = 7'h48;  // equals
            4'hE: sym_seg = 7'h63;  // degree
            default: sym_seg = 7'h00;  // blank
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_SPECIAL: seg = sym_seg;
            MODE_RAW:     seg = {3'b000, nib};
            default:      seg = hex_seg;
        endcase
    end
endmodule

// File: rtl/segdec_h_decoder.sv
module segdec_h_decoder #(
    parameter int NUM_BANKS  = 5,
    parameter int SEL_W      = 3,
    parameter int CODE_W     = 3,
    parameter int PAIR_BANKS = 2
) (
    input  logic [CODE_W-1:0] code,
    input  logic [SEL_W-1:0]  sel,
    output logic              h_on
);
    localparam logic [CODE_W-1:0] CODE_ALL  = '1;
    localparam logic [CODE_W-1:0] CODE_PAIR = CODE_ALL - 1'b1;

    logic [NUM_BANKS-1:0] hit;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
        if (g < PAIR_BANKS) begin : g_pair
            assign hit[g] = (code == CODE_ALL) || (code == CODE_PAIR)
                          || (code == CODE_W'(g + 1));
        end else begin : g_single
            assign hit[g] = (code == CODE_ALL) || (code == CODE_W'(g + 1));
        end
    end

    always_comb begin
        h_on = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (sel == SEL_W'(i)) h_on = hit[i];
        end
    end
endmodule

// File: rtl/seg_bank_decoder.sv
module seg_bank_decoder
    import segdec_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int NIB_W     = 4,
    parameter int SEL_W     = 3,
    parameter int GRP_SPLIT = 3,
    parameter int CODE_W    = 3,
    parameter int DISP_W    = NUM_BANKS * NIB_W + CODE_W + 1,
    parameter int CFG_W     = NUM_BANKS + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DISP_W-1:0] disp_word,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [SEL_W-1:0]  bank_sel,
    output logic [SEG_W-1:0]  seg_out,
    output logic              h_out
);
    localparam int CODE_LSB = NUM_BANKS * NIB_W;

    logic [NIB_W-1:0] cur_nib;
    glyph_mode_e      cur_mode;
    logic             cur_valid;
    logic [SEG_W-1:0] glyph;
    logic             h_on;
    logic             unused_bits;

    assign unused_bits = ^{disp_word[DISP_W-1], cfg_word[0]};

    segdec_bank_select #(
        .NUM_BANKS (NUM_BANKS),
        .NIB_W     (NIB_W),
        .SEL_W     (SEL_W),
        .GRP_SPLIT (GRP_SPLIT),
        .DISP_W    (DISP_W),
        .CFG_W     (CFG_W)
    ) u_sel (
        .disp  (disp_word),
        .cfg   (cfg_word),
        .sel   (bank_sel),
        .nib   (cur_nib),
        .mode  (cur_mode),
        .valid (cur_valid)
    );

    segdec_glyph_rom u_rom (
        .nib  (cur_nib),
        .mode (cur_mode),
        .seg  (glyph)
    );

    segdec_h_decoder #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .CODE_W    (CODE_W)
    ) u_hdec (
        .code (disp_word[CODE_LSB +: CODE_W]),
        .sel  (bank_sel),
        .h_on (h_on)
    );

    drive_s st_d, st_q;

    always_comb begin
        st_d = '0;
        if (cur_valid) begin
            st_d.seg = glyph;
            st_d.h   = h_on;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seg_out = st_q.seg;
    assign h_out   = st_q.h;
endmodule

// File: rtl/seg_bank_decoder_chk.sv
module seg_bank_decoder_chk #(
    parameter int NUM_BANKS = 5,
    parameter int NIB_W     = 4,
    parameter int SEL_W     = 3,
    parameter int GRP_SPLIT = 3,
    parameter int CODE_W    = 3,
    parameter int DISP_W    = 24,
    parameter int CFG_W     = 8,
    parameter int SEG_W     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DISP_W-1:0] disp_word,
    input logic [CFG_W-1:0]  cfg_word,
    input logic [SEL_W-1:0]  bank_sel,
    input logic [SEG_W-1:0]  seg_out,
    input logic              h_out
);
    logic [NIB_W-1:0]  nib_now;
    logic              in_range;
    logic              hex_now;
    logic              raw_now;
    logic [CODE_W-1:0] code_now;

    assign code_now = disp_word[NUM_BANKS*NIB_W +: CODE_W];

    always_comb begin
        nib_now  = '0;
        in_range = 1'b0;
        hex_now  = 1'b0;
        raw_now  = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_sel == SEL_W'(i)) begin
                nib_now  = disp_word[i*NIB_W +: NIB_W];
                in_range = 1'b1;
                hex_now  = !cfg_word[i+1];
                raw_now  = cfg_word[i+1]
                         && !cfg_word[(i < GRP_SPLIT) ? NUM_BANKS+1 : NUM_BANKS+2];
            end
        end
    end

    AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && raw_now) |=> (seg_out[SEG_W-1:NIB_W] == '0)
                                  && (seg_out[NIB_W-1:0] == $past(nib_now))); // R7

    AST_HEX_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && hex_now) |=> (seg_out != '0)); // R5

    AST_IDLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |=> (seg_out == '0) && !h_out); // R10

    AST_H_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_now == '0) |=> !h_out); // R8

    AST_H_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && code_now == '1) |=> h_out); // R9
endmodule

bind seg_bank_decoder seg_bank_decoder_chk #(
    .NUM_BANKS (NUM_BANKS),
    .NIB_W     (NIB_W),
    .SEL_W     (SEL_W),
    .GRP_SPLIT (GRP_SPLIT),
    .CODE_W    (CODE_W),
    .DISP_W    (DISP_W),
    .CFG_W     (CFG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .disp_word (disp_word),
    .cfg_word  (cfg_word),
    .bank_sel  (bank_sel),
    .seg_out   (seg_out),
    .h_out     (h_out)
);

// File: tb/sim_seg_bank_decoder.sv
module sim_seg_bank_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] disp_word = '0;
    logic [7:0]  cfg_word = '0;
    logic [2:0]  bank_sel = '0;
    logic [6:0]  seg_out;
    logic        h_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    seg_bank_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_word (disp_word),
        .cfg_word  (cfg_word),
        .bank_sel  (bank_sel),
        .seg_out   (seg_out),
        .h_out     (h_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [6:0] hex_tab(input logic [3:0] n);
        case (n)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
            4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
            4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    function automatic logic [6:0] sym_tab(input logic [3:0] n);
        case (n)
            4'h0: return 7'h58; 4'h1: return 7'h76; 4'h2: return 7'h74; 4'h3: return 7'h1E;
            4'h4: return 7'h38; 4'h5: return 7'h54; 4'h6: return 7'h5C; 4'h7: return 7'h73;
            4'h8: return 7'h50; 4'h9: return 7'h3E; 4'hA: return 7'h1C; 4'hB: return 7'h6E;
            4'hC: return 7'h40; 4'hD: return 7'h48; 4'hE: return 7'h63; default: return 7'h00;
        endcase
    endfunction

    // 0 = hex, 1 = symbol, 2 = raw (R4)
    function automatic int mode_of(input logic [7:0] c, input logic [2:0] s);
        logic grp;
        if (!c[s+1]) return 0;
        grp = (s < 3) ? c[6] : c[7];
        return grp ? 1 : 2;
    endfunction

    function automatic logic [6:0] exp_seg(input logic [23:0] d, input logic [7:0] c,
                                           input logic [2:0] s);
        logic [3:0] nib;
        int idx;
        if (s > 3'd4) return 7'h00;
        idx = int'(s);
        nib = d[idx*4 +: 4];
        case (mode_of(c, s))
            0:       return hex_tab(nib);
            1:       return sym_tab(nib);
            default: return {3'b000, nib};
        endcase
    endfunction

    function automatic logic exp_h(input logic [23:0] d, input logic [2:0] s);
        logic [2:0] code;
        if (s > 3'd4) return 1'b0;
        code = d[22:20];
        case (code)
            3'd0:    return 1'b0;
            3'd6:    return s < 3'd2;
            3'd7:    return 1'b1;
            default: return s == code - 3'd1;
        endcase
    endfunction

    task automatic report(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_vec(input logic [23:0] d, input logic [7:0] c, input logic [2:0] s,
                             input string seg_tag, input string h_tag);
        @(negedge clk);
        disp_word = d;
        cfg_word  = c;
        bank_sel  = s;
        @(negedge clk);
        report(seg_tag, int'(seg_out), int'(exp_seg(d, c, s)));
        report(h_tag, int'(h_out), int'(exp_h(d, s)));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] d;
        logic [7:0]  c;
        logic [2:0]  s;
        int          m;
        void'($urandom(32'd20240611));

        // R1: reset holds outputs low despite lit inputs
        disp_word = 24'hFF_FFFF;
        cfg_word  = 8'h00;
        bank_sel  = 3'd0;
        repeat (3) @(negedge clk);
        report("R1", int'(seg_out), 0);
        report("R1", int'(h_out), 0);
        rst_n = 1'b1;

        // R2: output changes only after the next rising edge
        check_vec(24'h00_0008, 8'h00, 3'd0, "R2", "R8");
        @(negedge clk);
        disp_word = 24'h00_0001;
        #1;
        report("R2", int'(seg_out), 32'h7F);
        @(negedge clk);
        report("R2", int'(seg_out), 32'h06);

        // R3: distinct nibble per bank, hex mode
        for (int b = 0; b < 5; b++)
            check_vec(24'h0A_4321 | 24'h01_0000 * 5, 8'h00, 3'(b), "R3", "R8");

        // R5: full hex table on every bank
        for (int b = 0; b < 5; b++)
            for (int n = 0; n < 16; n++)
                check_vec(24'(n) << (4*b), 8'h00, 3'(b), "R5", "R8");

        // R6: symbol table on bank 1 (C1+C6) and bank 4 (C4+C7)
        for (int n = 0; n < 16; n++) begin
            check_vec(24'(n), 8'h42, 3'd0, "R6", "R9");
            check_vec(24'(n) << 12, 8'h90, 3'd3, "R6", "R9");
        end

        // R7: raw mode on every bank
        for (int b = 0; b < 5; b++)
            for (int n = 0; n < 16; n++)
                check_vec(24'(n) << (4*b), 8'h3E, 3'(b), "R7", "R9");

        // R4: low group raw, high group symbol, with nibble 8
        for (int b = 0; b < 5; b++)
            check_vec(24'h08_8888, 8'hBE, 3'(b), "R4", "R9");
        // R4: only bank 2 switched out of hex, group bits set
        for (int b = 0; b < 5; b++)
            check_vec(24'h0_8888 | 24'h08_0000, 8'hC4, 3'(b), "R4", "R9");

        // R8: every h code on every select value
        for (int code = 0; code < 8; code++)
            for (int b = 0; b < 8; b++)
                check_vec({1'b0, 3'(code), 20'h12345}, 8'h00, 3'(b), "R8", "R8");

        // R9: h unchanged across the three modes
        for (int code = 0; code < 8; code++)
            for (int b = 0; b < 5; b++) begin
                check_vec({1'b0, 3'(code), 20'hABCDE}, 8'hFE, 3'(b), "R6", "R9");
                check_vec({1'b0, 3'(code), 20'hABCDE}, 8'h3E, 3'(b), "R7", "R9");
            end

        // R10: out-of-range selects with everything lit
        for (int b = 5; b < 8; b++)
            check_vec(24'hFF_FFFF, 8'hFF, 3'(b), "R10", "R10");

        // R11: unused bits toggled, outputs match the clean vector
        for (int b = 0; b < 5; b++) begin
            check_vec(24'h35_A5C3, 8'h54, 3'(b), "R11", "R11");
            check_vec(24'hB5_A5C3, 8'h55, 3'(b), "R11", "R11");
        end

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            d = 24'($urandom);
            c = 8'($urandom);
            s = 3'($urandom);
            m = (s > 3'd4) ? 3 : mode_of(c, s);
            case (m)
                0:       check_vec(d, c, s, "R5", "R8");
                1:       check_vec(d, c, s, "R6", "R9");
                2:       check_vec(d, c, s, "R7", "R9");
                default: check_vec(d, c, s, "R10", "R10");
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule